// File: doc/BRIEF.md
# Digit Blanking and Eight-Step Dimming Controller

This block decides, cycle by cycle, which character positions of a small dot-matrix display may drive their LEDs. It combines an active-low external blank input with three software fields: a master blank bit, a per-digit keep-lit mask and a three-bit brightness code. A compatibility switch turns off every software control, so that only the external input can blank the display.

Brightness comes from an internal pulse-width gate. A prescaler divides the clock into slot ticks. A slot counter runs over a fixed 30-slot period and compares its count with a per-code slot budget. The brightness code is sampled only when a period ends, so the gate never produces a short or stretched pulse when software changes the code. The external blank input can also carry a user-supplied PWM waveform for external dimming. Each digit enable is the internal gate ANDed with that digit's blank decision.

Top module: `digit_blank_dimmer`

## Requirements
- R1: After reset the active brightness code is 000. With the default variant, blank_n high, master_blank low and ext_disable low, pwm_gate and all digit_en bits are 1.
- R2: The period is 30 slots of PRESCALE clocks each. Within every period pwm_gate is high for exactly slots × PRESCALE clocks, where the codes 0 to 7 have slot budgets of 30, 18, 12, 8, 5, 3, 2 and 1.
- R3: With LOW_START set, code 000 has a budget of 8 slots, and code 001 keeps its budget of 18.
- R4: When ext_disable is 1, pwm_gate stays at 1 for every brightness code, master_blank and digit_keep have no effect, and every digit_en bit equals blank_n.
- R5: When ext_disable is 0 and either blank_n is 0 or master_blank is 1, every digit whose digit_keep bit is 0 has digit_en = 0.
- R6: When ext_disable is 0, a digit whose digit_keep bit is 1 has digit_en equal to pwm_gate, whatever blank_n and master_blank are.
- R7: A new bright_code is adopted only at the clock edge that ends a period. The period already running keeps its old slot budget.
- R8: No digit_en bit is ever 1 while pwm_gate is 0.
- R9: Within a period, pwm_gate forms one contiguous high run that starts at the period boundary. A period with a budget below 30 shows exactly one high-to-low change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the prescaler divides |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_n | input | 1 | External blank, active low; may carry a user PWM |
| master_blank | input | 1 | Software blank of the whole display |
| ext_disable | input | 1 | 1 ignores brightness, master blank and keep-lit mask |
| bright_code | input | 3 | Brightness step, 000 brightest, 111 dimmest |
| digit_keep | input | NUM_DIGITS | Per-digit keep-lit mask that overrides both blank sources |
| digit_en | output | NUM_DIGITS | Per-digit driver enable |
| pwm_gate | output | 1 | Internal dimming gate (forced high in compatibility mode) |

## Verification
The hardest case to reach is a brightness change in the middle of a period. The write must land at a known slot, and the period that is already running must still show the old budget while the next period shows the new one. The bench tracks the period phase itself by counting clocks from reset. It changes the code a fixed number of cycles after a boundary and measures the duty of two whole periods in turn. The blank combinations are applied while code 000 is active, so that the gate is held high and each digit enable shows only the blank decision.

// File: rtl/dimmer_pkg.sv
`timescale 1ns/1ps
package dimmer_pkg;
  localparam int SLOTS  = 30;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef logic [SLOT_W:0]   slot_lvl_t;
  typedef logic [SLOT_W-1:0] slot_idx_t;

  // Slots of the period during which the gate is high, per brightness step.
  function automatic slot_lvl_t duty_slots(input logic [2:0] code, input bit low_start);
    case (code)
      3'd0:    duty_slots = low_start ? slot_lvl_t'(8) : slot_lvl_t'(SLOTS);
      3'd1:    duty_slots = slot_lvl_t'(18);
      3'd2:    duty_slots = slot_lvl_t'(12);
      3'd3:    duty_slots = slot_lvl_t'(8);
      3'd4:    duty_slots = slot_lvl_t'(5);
      3'd5:    duty_slots = slot_lvl_t'(3);
      3'd6:    duty_slots = slot_lvl_t'(2);
      default: duty_slots = slot_lvl_t'(1);
    endcase
  endfunction

  // Per-digit blank decision: 1 = the digit may light.
  function automatic logic digit_lit(input logic ext_dis, input logic blank_n,
                                     input logic mblank, input logic keep);
    if (ext_dis) digit_lit = blank_n;
    else         digit_lit = keep | (blank_n & ~mblank);
  endfunction
endpackage

// File: rtl/dim_prescale.sv
`timescale 1ns/1ps
module dim_prescale #(
  parameter int PRESCALE = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic at_start
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick     = (cnt_q == LAST);
  assign at_start = (cnt_q == '0);
endmodule

// File: rtl/dim_duty.sv
`timescale 1ns/1ps
module dim_duty
  import dimmer_pkg::*;
#(
  parameter bit LOW_START = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] bright_code,
  output logic       gate_raw,
  output logic       period_wrap,
  output logic       slot_zero,
  output logic [2:0] active_code
);
  localparam slot_idx_t LAST_SLOT = slot_idx_t'(SLOTS - 1);

  slot_idx_t  slot_q;
  logic [2:0] code_q;
  slot_lvl_t  budget;

  assign period_wrap = tick && (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      code_q <= 3'd0;
    end else if (tick) begin
      if (period_wrap) begin
        slot_q <= '0;
        code_q <= bright_code;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign budget      = duty_slots(code_q, LOW_START);
  assign gate_raw    = ({1'b0, slot_q} < budget);
  assign slot_zero   = (slot_q == '0);
  assign active_code = code_q;
endmodule

// File: rtl/dim_blank.sv
`timescale 1ns/1ps
module dim_blank
  import dimmer_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                  ext_disable,
  input  logic                  blank_n,
  input  logic                  master_blank,
  input  logic [NUM_DIGITS-1:0] digit_keep,
  input  logic                  gate,
  output logic [NUM_DIGITS-1:0] digit_en
);
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    assign digit_en[d] = gate & digit_lit(ext_disable, blank_n, master_blank, digit_keep[d]);
  end
endmodule

// File: rtl/digit_blank_dimmer.sv
`timescale 1ns/1ps
module digit_blank_dimmer #(
  parameter int NUM_DIGITS = 4,
  parameter int PRESCALE   = 32,
  parameter bit LOW_START  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blank_n,
  input  logic                  master_blank,
  input  logic                  ext_disable,
  input  logic [2:0]            bright_code,
  input  logic [NUM_DIGITS-1:0] digit_keep,
  output logic [NUM_DIGITS-1:0] digit_en,
  output logic                  pwm_gate
);
  logic       tick;
  logic       pre_zero;
  logic       gate_raw;
  logic       period_wrap;
  logic       slot_zero;
  logic       period_begin;
  logic [2:0] active_code;

  dim_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .at_start(pre_zero)
  );

  dim_duty #(.LOW_START(LOW_START)) u_duty (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bright_code(bright_code),
    .gate_raw(gate_raw), .period_wrap(period_wrap), .slot_zero(slot_zero),
    .active_code(active_code)
  );

  assign period_begin = pre_zero & slot_zero;
  assign pwm_gate     = ext_disable | gate_raw;

  dim_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
    .ext_disable(ext_disable), .blank_n(blank_n), .master_blank(master_blank),
    .digit_keep(digit_keep), .gate(pwm_gate), .digit_en(digit_en)
  );
endmodule

// File: rtl/digit_blank_dimmer_chk.sv
`timescale 1ns/1ps
module digit_blank_dimmer_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  blank_n,
  input logic                  master_blank,
  input logic                  ext_disable,
  input logic [NUM_DIGITS-1:0] digit_keep,
  input logic [NUM_DIGITS-1:0] digit_en,
  input logic                  pwm_gate,
  input logic                  gate_raw,
  input logic                  period_wrap,
  input logic                  period_begin,
  input logic                  pre_zero,
  input logic [2:0]            active_code
);
  assert_gate_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en & ~{NUM_DIGITS{pwm_gate}}) == '0);

  assert_compat_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_disable |-> (pwm_gate && digit_en == {NUM_DIGITS{blank_n}}));

  assert_blank_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_disable && (!blank_n || master_blank)) |-> ((digit_en & ~digit_keep) == '0));

  assert_keep_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_disable && pwm_gate) |-> ((digit_en & digit_keep) == digit_keep));

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(active_code));

  assert_rise_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_raw) |-> period_begin);

  assert_fall_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_raw) |-> pre_zero);
endmodule

bind digit_blank_dimmer digit_blank_dimmer_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .master_blank(master_blank),
  .ext_disable(ext_disable), .digit_keep(digit_keep), .digit_en(digit_en),
  .pwm_gate(pwm_gate), .gate_raw(gate_raw), .period_wrap(period_wrap),
  .period_begin(period_begin), .pre_zero(pre_zero), .active_code(active_code)
);

// File: tb/digit_blank_dimmer_tb_top.sv
`timescale 1ns/1ps
module digit_blank_dimmer_tb_top;
  localparam int ND = 4;
  localparam int P  = 4;
  localparam int PP = 30 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank_n = 1'b1;
  logic master_blank = 1'b0;
  logic ext_disable = 1'b0;
  logic [2:0] bright_code = 3'd0;
  logic [ND-1:0] digit_keep = '0;
  logic [ND-1:0] digit_en, digit_en_low;
  logic pwm_gate, pwm_gate_low;

  always #5 clk = ~clk;

  digit_blank_dimmer #(.NUM_DIGITS(ND), .PRESCALE(P), .LOW_START(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .master_blank(master_blank),
    .ext_disable(ext_disable), .bright_code(bright_code), .digit_keep(digit_keep),
    .digit_en(digit_en), .pwm_gate(pwm_gate)
  );

  digit_blank_dimmer #(.NUM_DIGITS(ND), .PRESCALE(P), .LOW_START(1'b1)) dut_low_i (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .master_blank(master_blank),
    .ext_disable(ext_disable), .bright_code(bright_code), .digit_keep(digit_keep),
    .digit_en(digit_en_low), .pwm_gate(pwm_gate_low)
  );

  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct { string req; string what; int val; } item_t;
  item_t exp_q[$];
  int    act_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic expect_val(input string req, input string what, input int val, input int act);
    item_t it;
    it.req = req; it.what = what; it.val = val;
    exp_q.push_back(it);
    act_q.push_back(act);
  endtask

  task automatic compare_pending();
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t it;
      int a;
      it = exp_q.pop_front();
      a  = act_q.pop_front();
      checks++;
      if (a != it.val) begin
        errors++;
        $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what, a, it.val);
      end
    end
  endtask

  always @(posedge clk) compare_pending();

  int budget_tab[8] = '{30, 18, 12, 8, 5, 3, 2, 1};

  int hi_m, hi_l, all_on, leak, falls;

  task automatic run_period();
    logic prev;
    do @(negedge clk); while (cyc % PP != 0);
    hi_m = 0; hi_l = 0; all_on = 0; leak = 0; falls = 0; prev = 1'b1;
    for (int k = 0; k < PP; k++) begin
      #1;
      if (pwm_gate) hi_m++;
      if (pwm_gate_low) hi_l++;
      if (digit_en == '1) all_on++;
      if (!pwm_gate && digit_en != '0) leak++;
      if (prev && !pwm_gate) falls++;
      prev = pwm_gate;
      @(negedge clk);
    end
  endtask

  task automatic set_blank(input logic bn, input logic mb, input logic ed, input logic [ND-1:0] kp);
    @(negedge clk);
    blank_n = bn; master_blank = mb; ext_disable = ed; digit_keep = kp;
    #1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    expect_val("R1", "pwm_gate after reset", 1, pwm_gate);
    expect_val("R1", "digit_en after reset", 15, digit_en);
    expect_val("R1", "low variant gate in slot 0", 1, pwm_gate_low);

    // R2 / R3 / R8 / R9: duty per code
    for (int c = 0; c < 8; c++) begin
      bright_code = 3'(c);
      run_period();
      expect_val("R2", $sformatf("high clocks code %0d", c), budget_tab[c] * P, hi_m);
      if (c == 0) expect_val("R3", "low variant code 0", 8 * P, hi_l);
      if (c == 1) expect_val("R3", "low variant code 1", 18 * P, hi_l);
      if (c == 7) begin
        expect_val("R8", "enable while gate low", 0, leak);
        expect_val("R8", "all digits on clocks code 7", P, all_on);
      end
      if (c == 5) expect_val("R9", "high-to-low changes code 5", 1, falls);
    end

    // R7: change mid period
    bright_code = 3'd3;
    run_period();
    expect_val("R7", "code 3 settled", 8 * P, hi_m);
    hi_m = 0;
    for (int k = 0; k < PP; k++) begin
      #1;
      if (pwm_gate) hi_m++;
      if (k == 10) bright_code = 3'd7;
      @(negedge clk);
    end
    expect_val("R7", "period with mid change keeps old duty", 8 * P, hi_m);
    hi_m = 0;
    for (int k = 0; k < PP; k++) begin
      #1;
      if (pwm_gate) hi_m++;
      @(negedge clk);
    end
    expect_val("R7", "next period uses new duty", 1 * P, hi_m);

    // restore full brightness so the gate stays high
    bright_code = 3'd0;
    run_period();
    expect_val("R2", "code 0 restored", 30 * P, hi_m);

    // R5 / R6
    set_blank(1'b0, 1'b0, 1'b0, 4'b0101);
    expect_val("R6", "pin blank with keep 0101", 5, digit_en);
    set_blank(1'b1, 1'b1, 1'b0, 4'b0000);
    expect_val("R5", "master blank, no keep", 0, digit_en);
    set_blank(1'b1, 1'b1, 1'b0, 4'b1010);
    expect_val("R6", "master blank with keep 1010", 10, digit_en);
    set_blank(1'b0, 1'b1, 1'b0, 4'b0000);
    expect_val("R5", "both blank sources", 0, digit_en);
    set_blank(1'b1, 1'b0, 1'b0, 4'b0000);
    expect_val("R5", "no blank source", 15, digit_en);

    // R4: compatibility mode
    set_blank(1'b1, 1'b1, 1'b1, 4'b0101);
    expect_val("R4", "master blank ignored", 15, digit_en);
    set_blank(1'b0, 1'b0, 1'b1, 4'b0101);
    expect_val("R4", "keep ignored, pin blanks", 0, digit_en);
    set_blank(1'b1, 1'b0, 1'b1, 4'b0000);
    bright_code = 3'd7;
    run_period();
    run_period();
    expect_val("R4", "gate full with code 7", PP, hi_m);
    expect_val("R4", "digits full with code 7", PP, all_on);

    @(negedge clk);
    @(negedge clk);
    compare_pending();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule